// File: doc/BRIEF.md
# Tree-Structured Unsigned Magnitude Comparator

This block decides the ordering of two unsigned operands of a parameterised width (8 bits by default). It reports the answer on two flags: one raised when the first operand is larger, one raised when it is smaller, and neither raised when the operands are equal. No separate equality output exists. Equality is read as both flags low.

The comparison is built from one small precedence cell that is used again and again. Each cell takes two two-bit "digits": a high-order one and a low-order one. A digit is either a raw bit pair from the two operands or a (greater, less) flag pair from a cell below. The high-order digit decides the output whenever its two halves differ. When they agree, the low-order digit's relation passes through. A digit whose two halves are both 1 counts as a tie, just as both 0 does. The cells form a balanced binary tree, so an 8-bit compare needs 7 cells in 3 levels and the result passes through only 3 cells.

A parameter can place a register after every tree level. The result then appears a fixed number of clock edges later, equal to the number of levels. Without that parameter the block is purely combinational. The width must be a power of two and at least 2; any other value stops elaboration.

Top module: `mag_tree_cmp`

## Requirements
- R1: When op_x is greater than op_y as unsigned numbers, gt_o is 1 and lt_o is 0.
- R2: When op_x is less than op_y as unsigned numbers, lt_o is 1 and gt_o is 0.
- R3: When op_x equals op_y, both gt_o and lt_o are 0.
- R4: The most significant bit position where the operands differ alone sets the result, whatever the bits below it hold (for example 0x80 against 0x7F gives gt_o=1).
- R5: gt_o and lt_o are never 1 in the same cycle.
- R6: A bit position where both operands hold 1 acts as a tie exactly as one where both hold 0, so 0xFF against 0xFF gives both flags 0, and 0xFF against 0xFE gives gt_o=1.
- R7: With PIPELINE=0 the flags follow the operands within the same cycle, with no clock edge in between.
- R8: With PIPELINE=1 the flags for operands presented before a rising edge appear after log2(WIDTH) rising edges (3 for WIDTH=8), one result per cycle. While rst_n is low, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional level registers and the checks |
| rst_n | input | 1 | Asynchronous reset, active low; clears the level registers |
| op_x | input | WIDTH | First unsigned operand |
| op_y | input | WIDTH | Second unsigned operand |
| gt_o | output | 1 | High when op_x is greater than op_y |
| lt_o | output | 1 | High when op_x is less than op_y |

## Verification
The bench goes after operand pairs that differ only in their top bit while the lower bits lean the other way. A tree that let a lower digit override a higher one would report the wrong direction on these pairs. Bit positions holding 1 in both operands are probed next to positions holding 0 in both. A cell that read a (1,1) digit as a decision would raise both flags, or a wrong one, on equal all-ones operands. A walking single-bit difference at every position checks the wiring of each subtree, where a swapped cell input would flip the result at one position only. The registered variant receives a back-to-back stream, so an extra or missing stage would shift every result by a cycle. Its flags are also held while reset is asserted, where an unreset register would leak a result.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  // One comparison digit: a raw (x,y) bit pair or a (greater, less) flag pair.
  typedef struct packed {
    logic gt;
    logic lt;
  } rel_t;

  // Precedence merge: the high digit decides unless its halves agree.
  function automatic rel_t rel_merge(rel_t hi, rel_t lo);
    rel_t r;
    logic hi_tie;
    hi_tie = (hi.gt == hi.lt);
    r.gt = (hi.gt & ~hi.lt) | (hi_tie & lo.gt & ~lo.lt);
    r.lt = (hi.lt & ~hi.gt) | (hi_tie & lo.lt & ~lo.gt);
    return r;
  endfunction

  // Offset of the first node of a tree level inside the flat node vector.
  function automatic int level_base(int width, int lvl);
    return 2 * width - ((2 * width) >> lvl);
  endfunction

endpackage

// File: rtl/mtc_cell.sv
module mtc_cell
  import mtc_pkg::*;
(
  input  rel_t hi_d,
  input  rel_t lo_d,
  output rel_t rel_o
);

  logic hi_says_gt;
  logic hi_says_lt;
  logic hi_is_tie;

  assign hi_says_gt = hi_d.gt & ~hi_d.lt;
  assign hi_says_lt = hi_d.lt & ~hi_d.gt;
  assign hi_is_tie  = ~(hi_says_gt | hi_says_lt);

  assign rel_o = rel_merge(hi_d, lo_d);

  always_comb begin
    if (hi_says_gt) begin
      a_r4_hi_gt_wins: assert (rel_o.gt && !rel_o.lt);
    end
    if (hi_says_lt) begin
      a_r4_hi_lt_wins: assert (rel_o.lt && !rel_o.gt);
    end
    if (hi_is_tie && (lo_d.gt == lo_d.lt)) begin
      a_r6_tie_tie_quiet: assert (!rel_o.gt && !rel_o.lt);
    end
  end

endmodule

// File: rtl/mtc_level.sv
module mtc_level
  import mtc_pkg::*;
#(
  parameter int NIN = 8,
  parameter bit REG = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rel_t [NIN-1:0]      din,
  output rel_t [NIN/2-1:0]    dout
);

  localparam int NOUT = NIN / 2;

  rel_t [NOUT-1:0] merged;

  for (genvar j = 0; j < NOUT; j++) begin : g_cell
    mtc_cell u_cell (
      .hi_d  (din[2*j+1]),
      .lo_d  (din[2*j]),
      .rel_o (merged[j])
    );
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else        dout <= merged;
    end
  end else begin : g_comb
    assign dout = merged;
  end

endmodule

// File: rtl/mag_tree_cmp.sv
module mag_tree_cmp
  import mtc_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit PIPELINE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  output logic             gt_o,
  output logic             lt_o
);

  localparam int LEVELS = $clog2(WIDTH);
  localparam int NODES  = 2 * WIDTH - 1;

  if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
    $error("mag_tree_cmp: WIDTH must be a power of two of at least 2");
  end

  // Flat node store: leaves first, then each level's outputs, root last.
  rel_t [NODES-1:0] node;
  rel_t             root;

  for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
    assign node[i] = {op_x[i], op_y[i]};
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NIN  = WIDTH >> l;
    localparam int BIN  = level_base(WIDTH, l);
    localparam int BOUT = level_base(WIDTH, l + 1);
    mtc_level #(
      .NIN (NIN),
      .REG (PIPELINE)
    ) u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (node[BIN+NIN-1:BIN]),
      .dout  (node[BOUT+NIN/2-1:BOUT])
    );
  end

  assign root = node[NODES-1];
  assign gt_o = root.gt;
  assign lt_o = root.lt;

  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(gt_o && lt_o));

  if (!PIPELINE) begin : g_chk_comb
    a_r1_greater: assert property (@(posedge clk) disable iff (!rst_n)
      (op_x > op_y) |-> (gt_o && !lt_o));
    a_r2_less: assert property (@(posedge clk) disable iff (!rst_n)
      (op_x < op_y) |-> (lt_o && !gt_o));
    a_r3_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (op_x == op_y) |-> (!gt_o && !lt_o));
  end else begin : g_chk_pipe
    a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!gt_o && !lt_o));
  end

endmodule

// File: tb/mag_tree_cmp_tb.sv
module mag_tree_cmp_tb;

  localparam int W   = 8;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] x = '0, y = '0;
  logic         gt_c, lt_c, gt_p, lt_p;
  int           n_chk = 0;
  int           n_fail = 0;

  always #4 clk = ~clk;

  mag_tree_cmp #(.WIDTH(W), .PIPELINE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_x(x), .op_y(y), .gt_o(gt_c), .lt_o(lt_c));

  mag_tree_cmp #(.WIDTH(W), .PIPELINE(1'b1)) u_dut_pipe (
    .clk(clk), .rst_n(rst_n), .op_x(x), .op_y(y), .gt_o(gt_p), .lt_o(lt_p));

  function automatic logic [1:0] ref_rel(logic [W-1:0] a, logic [W-1:0] b);
    int ia = a;
    int ib = b;
    return {ia > ib, ib > ia};
  endfunction

  task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s x=%02h y=%02h got gt,lt=%b expected %b", req, x, y, got, exp);
    end
  endtask

  task automatic apply_comb(string req, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    x = a; y = b;
    #1;
    chk(req, {gt_c, lt_c}, ref_rel(a, b));
    if (gt_c && lt_c) chk("R5", {gt_c, lt_c}, 2'b00);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    @(negedge clk);
    x = 8'hFF; y = 8'h00;
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
    chk("R8 reset", {gt_p, lt_p}, 2'b00);
    rst_n = 1'b1;
  endtask

  task automatic t_basic;
    apply_comb("R1", 8'h05, 8'h03);
    apply_comb("R1", 8'h01, 8'h00);
    apply_comb("R2", 8'h03, 8'h05);
    apply_comb("R2", 8'h00, 8'hFF);
    apply_comb("R3", 8'h5A, 8'h5A);
    apply_comb("R3", 8'h00, 8'h00);
  endtask

  task automatic t_ties;
    apply_comb("R6", 8'hFF, 8'hFF);
    apply_comb("R6", 8'hFF, 8'hFE);
    apply_comb("R6", 8'hF0, 8'hF1);
    apply_comb("R6", 8'hAA, 8'hAA);
  endtask

  task automatic t_dominance;
    apply_comb("R4", 8'h80, 8'h7F);
    apply_comb("R4", 8'h7F, 8'h80);
    for (int b = 0; b < W; b++) begin
      apply_comb("R4", W'(1 << b), W'((1 << b) - 1));
      apply_comb("R4", W'((1 << b) - 1), W'(1 << b));
      apply_comb("R1", W'(1 << b), 8'h00);
      apply_comb("R2", 8'h00, W'(1 << b));
    end
  endtask

  task automatic t_sweep;
    logic [15:0] lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (k % 5 == 0) apply_comb("R7", lf[7:0], lf[7:0]);
      else            apply_comb("R7", lf[15:8], lf[7:0]);
    end
  endtask

  task automatic t_stream;
    logic [1:0]  hist [0:63];
    logic [15:0] lf = 16'h1D2B;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (k >= LAT) chk("R8 stream", {gt_p, lt_p}, hist[k-LAT]);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (k % 7 == 3) begin x = lf[7:0]; y = lf[7:0]; end
      else begin x = lf[15:8]; y = lf[7:0]; end
      hist[k] = ref_rel(x, y);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_ties();
    t_dominance();
    t_sweep();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule